// File: doc/BRIEF.md
# Disk Data FIFO with Threshold Transfer Requests

This block holds a 16-byte data queue between a host bus and a disk data engine. It tells the host side when to move data. The host side is either a DMA controller or a processor doing programmed I/O. A command start pulse opens the execution phase and selects the direction of the transfer. The block then raises its request by rules that depend on the direction and on a programmable byte threshold. It does not simply follow a not-empty or not-full flag.

In DMA mode the request appears on a DMA request line. Host accesses are only accepted while the DMA acknowledge is high, and a terminal-count input qualified by that acknowledge ends the transfer. In programmed-I/O mode the same request drives an interrupt line and a ready-for-master status bit instead, and a host strobe that carries terminal count ends the transfer. Once the transfer has been terminated and the queue has drained, the block reports that the result phase may begin. Overrun and underrun flags record illegal host accesses.

Top module: `fifoXferReq`

## Requirements
- R1: After reset, dmaReq, intReq, rqm, resultReady, overrun and underrun are 0 and fifoCount is 0.
- R2: In the host-to-disk direction (dirToHost=0), the request is high from the cycle after cmdStart and goes low in the same cycle that fifoCount reaches 16.
- R3: In the host-to-disk direction, once the request has dropped on full, it rises again as soon as fifoCount is at or below the effective threshold.
- R4: In the disk-to-host direction (dirToHost=1), the request rises when fifoCount is at least 16 minus the effective threshold. It then stays high until fifoCount is 0.
- R5: In the disk-to-host direction, a disk write carrying diskLast raises the request at any non-zero fill level, even below the threshold level.
- R6: In DMA mode (dmaMode=1), tc and dack both high during an active transfer force dmaReq low from the next cycle on, with or without a host strobe.
- R7: In DMA mode the request appears only on dmaReq. In programmed-I/O mode it appears only on intReq, and rqm always equals intReq.
- R8: In programmed-I/O mode, a host write or read with tc high stores or delivers its byte and ends the request from the next cycle.
- R9: resultReady becomes 1 one cycle after the transfer has been terminated and fifoCount is 0. It is never 1 while the queue holds data.
- R10: A host write to a full queue in the host-to-disk direction sets overrun, stores nothing and leaves fifoCount at 16.
- R11: A host read from an empty queue in the disk-to-host direction sets underrun.
- R12: cmdStart clears overrun, underrun, resultReady and the queue contents.
- R13: A threshold value of 0 behaves exactly like a threshold of 1.
- R14: Bytes leave the queue in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | Pulse that enters the execution phase of a new command |
| dmaMode | input | 1 | 1 = DMA handshake, 0 = programmed I/O |
| dirToHost | input | 1 | 1 = disk-to-host transfer, 0 = host-to-disk transfer |
| threshold | input | 4 | Request threshold in bytes (0 treated as 1) |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data |
| hostRd | input | 1 | Host read strobe |
| hostRdData | output | 8 | Byte at the queue head for the host |
| dack | input | 1 | DMA acknowledge |
| tc | input | 1 | Terminal count |
| diskWr | input | 1 | Disk engine write strobe |
| diskWrData | input | 8 | Disk engine write data |
| diskLast | input | 1 | Marks the final byte of a full sector on a disk write |
| diskRd | input | 1 | Disk engine read strobe |
| diskRdData | output | 8 | Byte at the queue head for the disk engine |
| dmaReq | output | 1 | DMA request |
| intReq | output | 1 | Interrupt request in programmed-I/O mode |
| rqm | output | 1 | Ready-for-master status bit |
| resultReady | output | 1 | Result phase may begin |
| overrun | output | 1 | Sticky: host wrote to a full queue |
| underrun | output | 1 | Sticky: host read from an empty queue |
| fifoCount | output | 5 | Number of bytes held in the queue |

## Verification
A corrupted fill count or a stale hysteresis bit shows up at once on dmaReq or intReq. The request then rises or falls one or more bytes away from the level predicted from the threshold, and this is visible in the very cycle the count crosses that level. A wrong read or write pointer shows up on hostRdData as a byte out of sequence at the first read after the fault. A termination flag that is lost or set by mistake either keeps the request alive after terminal count or pulls resultReady early, within one cycle of the tc strobe or of the queue draining.

// File: rtl/fifoReqPkg.sv
package fifoReqPkg;
  // Strobes from the request control to the byte store
  typedef struct packed {
    logic clear;        // empty the queue at command start
    logic push;         // write one byte
    logic pushFromHost; // 1: byte from host bus, 0: from disk engine
    logic pop;          // remove the head byte
  } fifoStrobes_t;
endpackage

// File: rtl/fifoStore.sv
module fifoStore
  import fifoReqPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fifoStrobes_t                 strb,
  input  logic [DW-1:0]                hostData,
  input  logic [DW-1:0]                diskData,
  output logic [DW-1:0]                headData,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [DW-1:0] pushData;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushData = strb.pushFromHost ? hostData : diskData;
  assign headData = mem[rdPtr];
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);

  always_ff @(posedge clk) begin
    if (strb.push && !strb.clear) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fifoReqCtrl.sv
module fifoReqCtrl
  import fifoReqPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cmdStart,
  input  logic                        dmaMode,
  input  logic                        dirToHost,
  input  logic [$clog2(DEPTH)-1:0]    threshold,
  input  logic                        hostWr,
  input  logic                        hostRd,
  input  logic                        dack,
  input  logic                        tc,
  input  logic                        diskWr,
  input  logic                        diskRd,
  input  logic                        diskLast,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  input  logic                        full,
  input  logic                        empty,
  output fifoStrobes_t                strb,
  output logic                        dmaReq,
  output logic                        intReq,
  output logic                        rqm,
  output logic                        resultReady,
  output logic                        overrun,
  output logic                        underrun
);
  localparam int CW = $clog2(DEPTH + 1);

  logic active, termSeen, armed, sectorEnd, resultPhase;
  logic hostWrOk, hostRdOk, termSet, req;
  logic [CW-1:0] thrEff, fillLevel;

  // threshold of zero behaves as one
  assign thrEff    = (threshold == '0) ? CW'(1) : CW'(threshold);
  assign fillLevel = CW'(DEPTH) - thrEff;

  // in DMA mode the acknowledge acts as the select for host cycles
  assign hostWrOk = hostWr && (!dmaMode || dack);
  assign hostRdOk = hostRd && (!dmaMode || dack);

  assign termSet = active && (dmaMode ? (tc && dack)
                                      : (tc && (hostWrOk || hostRdOk)));

  always_comb begin
    strb       = '0;
    strb.clear = cmdStart;
    if (active && !cmdStart) begin
      if (!dirToHost) begin
        strb.pushFromHost = 1'b1;
        strb.push         = hostWrOk && !full;
        strb.pop          = diskRd && !empty;
      end else begin
        strb.pushFromHost = 1'b0;
        strb.push         = diskWr && !full;
        strb.pop          = hostRdOk && !empty;
      end
    end
  end

  // direction-dependent request with hysteresis held in 'armed'
  always_comb begin
    req = 1'b0;
    if (active && !termSeen) begin
      if (!dirToHost)
        req = !full && (armed || count <= thrEff);
      else
        req = !empty && (armed || count >= fillLevel || sectorEnd);
    end
  end

  assign dmaReq      = dmaMode && req;
  assign intReq      = !dmaMode && req;
  assign rqm         = intReq;
  assign resultReady = resultPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      termSeen    <= 1'b0;
      armed       <= 1'b0;
      sectorEnd   <= 1'b0;
      resultPhase <= 1'b0;
      overrun     <= 1'b0;
      underrun    <= 1'b0;
    end else if (cmdStart) begin
      active      <= 1'b1;
      termSeen    <= 1'b0;
      armed       <= !dirToHost;
      sectorEnd   <= 1'b0;
      resultPhase <= 1'b0;
      overrun     <= 1'b0;
      underrun    <= 1'b0;
    end else if (active) begin
      if (termSet) termSeen <= 1'b1;
      if (!dirToHost) begin
        if (full)                  armed <= 1'b0;
        else if (count <= thrEff)  armed <= 1'b1;
        if (hostWrOk && full)      overrun <= 1'b1;
      end else begin
        if (empty)                                  armed <= 1'b0;
        else if (count >= fillLevel || sectorEnd)   armed <= 1'b1;
        if (diskWr && diskLast && !full)            sectorEnd <= 1'b1;
        if (hostRdOk && empty)                      underrun <= 1'b1;
      end
      if (termSeen && empty) begin
        active      <= 1'b0;
        resultPhase <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fifoXferReq.sv
module fifoXferReq
  import fifoReqPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic          dmaMode,
  input  logic          dirToHost,
  input  logic [AW-1:0] threshold,
  input  logic          hostWr,
  input  logic [DW-1:0] hostWrData,
  input  logic          hostRd,
  output logic [DW-1:0] hostRdData,
  input  logic          dack,
  input  logic          tc,
  input  logic          diskWr,
  input  logic [DW-1:0] diskWrData,
  input  logic          diskLast,
  input  logic          diskRd,
  output logic [DW-1:0] diskRdData,
  output logic          dmaReq,
  output logic          intReq,
  output logic          rqm,
  output logic          resultReady,
  output logic          overrun,
  output logic          underrun,
  output logic [CW-1:0] fifoCount
);
  fifoStrobes_t strb;
  logic [DW-1:0] headData;
  logic full, empty;

  fifoStore #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostData(hostWrData), .diskData(diskWrData),
    .headData(headData), .count(fifoCount), .full(full), .empty(empty)
  );

  fifoReqCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .dmaMode(dmaMode),
    .dirToHost(dirToHost), .threshold(threshold),
    .hostWr(hostWr), .hostRd(hostRd), .dack(dack), .tc(tc),
    .diskWr(diskWr), .diskRd(diskRd), .diskLast(diskLast),
    .count(fifoCount), .full(full), .empty(empty), .strb(strb),
    .dmaReq(dmaReq), .intReq(intReq), .rqm(rqm),
    .resultReady(resultReady), .overrun(overrun), .underrun(underrun)
  );

  assign hostRdData = headData;
  assign diskRdData = headData;
endmodule

// File: rtl/fifoXferReqChk.sv
module fifoXferReqChk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdStart,
  input logic          dmaMode,
  input logic          dirToHost,
  input logic          dack,
  input logic          tc,
  input logic          dmaReq,
  input logic          intReq,
  input logic          rqm,
  input logic          resultReady,
  input logic          overrun,
  input logic [CW-1:0] fifoCount
);
  // R2
  full_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dirToHost && fifoCount == CW'(DEPTH)) |-> (!dmaReq && !intReq));

  // R4
  empty_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirToHost && fifoCount == '0) |-> (!dmaReq && !intReq));

  // R6
  tc_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && tc && dack && !cmdStart) |=> !dmaReq);

  // R7
  one_channel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaReq && intReq) && (rqm == intReq));

  // R9
  result_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultReady |-> (fifoCount == '0));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !cmdStart) |=> overrun);

  // R12
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> (!overrun && !resultReady && fifoCount == '0));
endmodule

bind fifoXferReq fifoXferReqChk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .dmaMode(dmaMode),
  .dirToHost(dirToHost), .dack(dack), .tc(tc), .dmaReq(dmaReq),
  .intReq(intReq), .rqm(rqm), .resultReady(resultReady),
  .overrun(overrun), .fifoCount(fifoCount)
);

// File: tb/test_fifoXferReq.sv
module test_fifoXferReq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, dmaMode = 0, dirToHost = 0;
  logic [3:0] threshold = 0;
  logic hostWr = 0, hostRd = 0, dack = 0, tc = 0;
  logic diskWr = 0, diskLast = 0, diskRd = 0;
  logic [7:0] hostWrData = 0, diskWrData = 0;
  logic [7:0] hostRdData, diskRdData;
  logic dmaReq, intReq, rqm, resultReady, overrun, underrun;
  logic [4:0] fifoCount;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  fifoXferReq i_fifoXferReq (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .dmaMode(dmaMode),
    .dirToHost(dirToHost), .threshold(threshold),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRd(hostRd),
    .hostRdData(hostRdData), .dack(dack), .tc(tc),
    .diskWr(diskWr), .diskWrData(diskWrData), .diskLast(diskLast),
    .diskRd(diskRd), .diskRdData(diskRdData),
    .dmaReq(dmaReq), .intReq(intReq), .rqm(rqm),
    .resultReady(resultReady), .overrun(overrun), .underrun(underrun),
    .fifoCount(fifoCount)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // {threshold, expected request level = 16 - effective threshold}
  localparam logic [7:0] VEC [5] = '{
    {4'd0, 4'd15}, {4'd1, 4'd15}, {4'd4, 4'd12}, {4'd8, 4'd8}, {4'd15, 4'd1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic dir, input logic dma, input logic [3:0] thr);
    dirToHost = dir; dmaMode = dma; threshold = thr; cmdStart = 1;
    tick();
    cmdStart = 0;
  endtask

  task automatic diskPush(input logic [7:0] d, input logic last);
    diskWr = 1; diskWrData = d; diskLast = last;
    tick();
    diskWr = 0; diskLast = 0;
  endtask

  task automatic diskPop();
    diskRd = 1;
    tick();
    diskRd = 0;
  endtask

  task automatic hostWrite(input logic [7:0] d, input logic withAck, input logic withTc);
    hostWr = 1; hostWrData = d; dack = withAck; tc = withTc;
    tick();
    hostWr = 0; dack = 0; tc = 0;
  endtask

  task automatic hostRead(input logic withAck);
    hostRd = 1; dack = withAck;
    tick();
    hostRd = 0; dack = 0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 dmaReq", dmaReq, 0);
    check("R1 intReq", intReq, 0);
    check("R1 rqm", rqm, 0);
    check("R1 resultReady", resultReady, 0);
    check("R1 flags", {overrun, underrun}, 0);
    check("R1 count", fifoCount, 0);
    rstN = 1;
    tick();

    // R4 R13 R14: table of thresholds, disk-to-host DMA
    for (int e = 0; e < 5; e++) begin
      automatic logic [3:0] thr = VEC[e][7:4];
      automatic int lvl = int'(VEC[e][3:0]);
      startCmd(1, 1, thr);
      for (int i = 0; i < 16; i++) begin
        diskPush(8'(i * 7 + e), 0);
        check($sformatf("R4 R13 rise thr=%0d cnt=%0d", thr, i + 1),
              dmaReq, ((i + 1) >= lvl) ? 1 : 0);
      end
      for (int j = 0; j < 16; j++) begin
        check("R4 hold until empty", dmaReq, 1);
        check("R14 order", hostRdData, 8'(j * 7 + e));
        hostRead(1);
      end
      check("R4 drop at empty", dmaReq, 0);
    end

    // R2 R3 R10 R6 R9: host-to-disk DMA, threshold 4
    startCmd(0, 1, 4'd4);
    check("R2 raise on start", dmaReq, 1);
    check("R7 no intReq in DMA", intReq, 0);
    for (int i = 0; i < 16; i++) hostWrite(8'(i + 100), 1, 0);
    check("R2 drop at full", dmaReq, 0);
    check("R2 count full", fifoCount, 16);
    hostWrite(8'hEE, 1, 0);
    check("R10 overrun set", overrun, 1);
    check("R10 count unchanged", fifoCount, 16);
    for (int i = 0; i < 11; i++) begin
      check("R14 disk order", diskRdData, 8'(i + 100));
      diskPop();
    end
    check("R3 low above threshold", dmaReq, 0);
    diskPop();
    check("R3 reassert at threshold", dmaReq, 1);
    tc = 1; dack = 1;
    tick();
    tc = 0; dack = 0;
    check("R6 tc with dack drops", dmaReq, 0);
    for (int i = 0; i < 4; i++) diskPop();
    check("R6 stays low", dmaReq, 0);
    check("R9 not yet", resultReady, 0);
    tick();
    check("R9 result ready", resultReady, 1);

    // R12 R11: programmed-I/O disk-to-host, underrun
    startCmd(1, 0, 4'd8);
    check("R12 overrun cleared", overrun, 0);
    check("R12 result cleared", resultReady, 0);
    hostRead(0);
    check("R11 underrun set", underrun, 1);
    diskPush(8'h11, 0);
    diskPush(8'h22, 0);
    check("R5 below level", intReq, 0);
    diskPush(8'h33, 1);
    check("R5 sector end raises", intReq, 1);
    check("R7 rqm follows", rqm, 1);
    check("R7 no dmaReq", dmaReq, 0);
    startCmd(1, 0, 4'd8);
    check("R12 underrun cleared", underrun, 0);

    // R7 R8 R13: programmed-I/O host-to-disk, threshold 0
    startCmd(0, 0, 4'd0);
    check("R7 intReq on start", intReq, 1);
    check("R7 rqm on start", rqm, 1);
    check("R7 dmaReq low", dmaReq, 0);
    for (int i = 0; i < 16; i++) hostWrite(8'(i), 0, 0);
    check("R7 intReq drop full", intReq, 0);
    for (int i = 0; i < 14; i++) diskPop();
    check("R13 count 2 no req", intReq, 0);
    diskPop();
    check("R13 reassert at 1", intReq, 1);
    hostWrite(8'h55, 0, 1);
    check("R8 last byte stored", fifoCount, 2);
    check("R8 request ends", intReq, 0);
    check("R8 rqm ends", rqm, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule